// File: doc/BRIEF.md
# DSP Core Status Word

This block keeps the 16-bit status word of a processor core that has two DSP accumulators. It gathers overflow and saturation events from both accumulators, the five ALU condition flags, a loop-active flag, a repeat-active flag and a 3-bit interrupt priority field. It presents all of them as one word that software can read.

Software writes the whole word in one strobe. Each bit then follows its own access rule. Some bits are read-only and ignore the write. Some are clear-only: a 0 clears the bit and a 1 leaves it as it is. The rest are plain read/write. Two summary bits are always the OR of their pair of flags, and a clear written to the saturation summary fans out to both sticky saturation flags.

A fourth priority bit arrives from outside. It is placed above the 3-bit field to form the effective 4-bit priority, and when it is 1 the block tells the interrupt logic to hold off user interrupts. When the nesting-disable input is 1, software cannot write the 3-bit field. All ports are plain control and status pins, with no stream handshakes.

Top module: `dsp_status_reg`

## Requirements
- R1: After reset, `status_q` is 0x0000, `eff_prio` is taken from `ipl_hi` alone (its low three bits are 0), and `user_irq_off` follows `ipl_hi`.
- R2: The status word has this layout: bit15 overflow A, bit14 overflow B, bit13 sticky saturation A, bit12 sticky saturation B, bit11 overflow summary, bit10 saturation summary, bit9 loop active, bit8 digit carry, bits7:5 priority, bit4 repeat active, bit3 negative, bit2 overflow, bit1 zero, bit0 carry.
- R3: In a cycle where `acc_wr[i]` is 1 (index 0 is accumulator A, index 1 is accumulator B), the overflow bit of accumulator i takes `acc_ovf[i]` at the next clock. Otherwise it holds. Software writes never change it.
- R4: When `acc_sat[i]` is 1, the sticky saturation bit of accumulator i is 1 after the clock. It then stays 1 until software clears it.
- R5: A software write with 0 in bit 13 or bit 12 clears that saturation bit. A 1 in that position leaves the bit unchanged, so software can never set bits 13, 12 or 10.
- R6: A software write with 0 in bit 10 clears both sticky saturation bits.
- R7: If a saturation event and a software clear of the same bit fall in the same cycle, the bit is 1 afterwards.
- R8: Bit 11 always equals bit15 OR bit14, and bit 10 always equals bit13 OR bit12.
- R9: Bits 9 and 4 show `loop_active` and `rpt_active` as they were one clock earlier. Software writes do not change them.
- R10: When `alu_we` is 1, bits {8,3,2,1,0} load `alu_flags[4:0]` in the order {DC,N,OV,Z,C}. Otherwise a software write loads them from the same positions of `sw_wr_data`. If both happen in one cycle, the ALU value wins.
- R11: `irq_ipl_we` loads `irq_ipl` into bits 7:5 and wins over software. A software write loads bits 7:5 only while `nest_dis` is 0. While `nest_dis` is 1, such a write leaves the field unchanged.
- R12: `eff_prio` equals {`ipl_hi`, bits 7:5}, and `user_irq_off` equals `ipl_hi`, both without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr_en | input | 1 | Software write strobe for the whole word |
| sw_wr_data | input | 16 | Word written by software |
| status_q | output | 16 | Status word as software reads it |
| acc_wr | input | 2 | Accumulator write strobes (0 = A, 1 = B) |
| acc_ovf | input | 2 | Overflow result that goes with each accumulator write |
| acc_sat | input | 2 | Saturation event for each accumulator |
| alu_we | input | 1 | ALU condition flag update strobe |
| alu_flags | input | 5 | New {DC,N,OV,Z,C} values |
| loop_active | input | 1 | Hardware loop is running |
| rpt_active | input | 1 | Single-instruction repeat is running |
| irq_ipl_we | input | 1 | Interrupt controller priority load strobe |
| irq_ipl | input | 3 | Priority value loaded by the interrupt controller |
| nest_dis | input | 1 | Nesting disabled; software cannot write the priority field |
| ipl_hi | input | 1 | Fourth priority bit from outside |
| eff_prio | output | 4 | Effective 4-bit priority |
| user_irq_off | output | 1 | User interrupts are disabled |

## Verification
Two pairs of functions can collide in one cycle. In the first, a saturation event and a software clear of the same sticky flag land together, either directly or through the summary bit. In the second, an ALU or interrupt-controller load coincides with a software write to the same field. Directed cycles drive each collision on purpose and check the winner against R7, R10 and R11. A long run of random strobes then compares every field each clock against a behavioural model, which also covers the nesting-disable gate on the priority field.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned NUM_ACC = 2;
  localparam int unsigned IPL_W   = 3;
  localparam int unsigned COND_W  = 5;

  // Bit positions of the status word
  localparam int unsigned P_OVF_A = 15;
  localparam int unsigned P_OVF_B = 14;
  localparam int unsigned P_SAT_A = 13;
  localparam int unsigned P_SAT_B = 12;
  localparam int unsigned P_OVF_S = 11;
  localparam int unsigned P_SAT_S = 10;
  localparam int unsigned P_LOOP  = 9;
  localparam int unsigned P_DC    = 8;
  localparam int unsigned P_IPL_L = 5;
  localparam int unsigned P_RPT   = 4;
  localparam int unsigned P_N     = 3;
  localparam int unsigned P_OV    = 2;
  localparam int unsigned P_Z     = 1;
  localparam int unsigned P_C     = 0;

  typedef struct packed {
    logic dc;
    logic n;
    logic ov;
    logic z;
    logic c;
  } cond_flags_t;
endpackage

// File: rtl/dsr_acc_flags.sv
module dsr_acc_flags #(
  parameter int unsigned N_ACC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ACC-1:0] acc_wr,
  input  logic [N_ACC-1:0] acc_ovf,
  input  logic [N_ACC-1:0] acc_sat,
  input  logic [N_ACC-1:0] sw_clr,
  output logic [N_ACC-1:0] ovf_q,
  output logic [N_ACC-1:0] sat_q
);
  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_q[i] <= 1'b0;
      end else if (acc_wr[i]) begin
        ovf_q[i] <= acc_ovf[i];
      end
    end

    // The saturation event has priority over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sat_q[i] <= 1'b0;
      end else if (acc_sat[i]) begin
        sat_q[i] <= 1'b1;
      end else if (sw_clr[i]) begin
        sat_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsr_cond_flags.sv
module dsr_cond_flags
  import dsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alu_we,
  input  cond_flags_t alu_flags,
  input  logic        sw_we,
  input  cond_flags_t sw_flags,
  output cond_flags_t flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (alu_we) begin
      flags_q <= alu_flags;
    end else if (sw_we) begin
      flags_q <= sw_flags;
    end
  end
endmodule

// File: rtl/dsr_prio.sv
module dsr_prio #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_we,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic             sw_we,
  input  logic             nest_dis,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             lvl_hi,
  output logic [LVL_W-1:0] lvl_q,
  output logic [LVL_W:0]   eff_lvl,
  output logic             user_off
);
  logic sw_ok;
  assign sw_ok = sw_we && !nest_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (irq_we) begin
      lvl_q <= irq_lvl;
    end else if (sw_ok) begin
      lvl_q <= sw_lvl;
    end
  end

  assign eff_lvl  = {lvl_hi, lvl_q};
  assign user_off = lvl_hi;
endmodule

// File: rtl/dsp_status_reg.sv
module dsp_status_reg
  import dsr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_wr_en,
  input  logic [WORD_W-1:0]        sw_wr_data,
  output logic [WORD_W-1:0]        status_q,
  input  logic [NUM_ACC-1:0]       acc_wr,
  input  logic [NUM_ACC-1:0]       acc_ovf,
  input  logic [NUM_ACC-1:0]       acc_sat,
  input  logic                     alu_we,
  input  logic [COND_W-1:0]        alu_flags,
  input  logic                     loop_active,
  input  logic                     rpt_active,
  input  logic                     irq_ipl_we,
  input  logic [IPL_W-1:0]         irq_ipl,
  input  logic                     nest_dis,
  input  logic                     ipl_hi,
  output logic [IPL_W:0]           eff_prio,
  output logic                     user_irq_off
);
  logic [NUM_ACC-1:0] sat_clr;
  logic [NUM_ACC-1:0] ovf_q;
  logic [NUM_ACC-1:0] sat_q;
  cond_flags_t        cond_q;
  cond_flags_t        sw_cond;
  logic [IPL_W-1:0]   ipl_q;
  logic               loop_q;
  logic               rpt_q;

  // A 0 in the summary position clears every sticky bit
  assign sat_clr[0] = sw_wr_en && (!sw_wr_data[P_SAT_A] || !sw_wr_data[P_SAT_S]);
  assign sat_clr[1] = sw_wr_en && (!sw_wr_data[P_SAT_B] || !sw_wr_data[P_SAT_S]);

  assign sw_cond = '{dc: sw_wr_data[P_DC], n: sw_wr_data[P_N], ov: sw_wr_data[P_OV],
                     z: sw_wr_data[P_Z], c: sw_wr_data[P_C]};

  dsr_acc_flags #(.N_ACC(NUM_ACC)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_wr (acc_wr),
    .acc_ovf(acc_ovf),
    .acc_sat(acc_sat),
    .sw_clr (sat_clr),
    .ovf_q  (ovf_q),
    .sat_q  (sat_q)
  );

  dsr_cond_flags u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .alu_we   (alu_we),
    .alu_flags(cond_flags_t'(alu_flags)),
    .sw_we    (sw_wr_en),
    .sw_flags (sw_cond),
    .flags_q  (cond_q)
  );

  dsr_prio #(.LVL_W(IPL_W)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_we  (irq_ipl_we),
    .irq_lvl (irq_ipl),
    .sw_we   (sw_wr_en),
    .nest_dis(nest_dis),
    .sw_lvl  (sw_wr_data[P_IPL_L +: IPL_W]),
    .lvl_hi  (ipl_hi),
    .lvl_q   (ipl_q),
    .eff_lvl (eff_prio),
    .user_off(user_irq_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      rpt_q  <= 1'b0;
    end else begin
      loop_q <= loop_active;
      rpt_q  <= rpt_active;
    end
  end

  always_comb begin
    status_q                      = '0;
    status_q[P_OVF_A]             = ovf_q[0];
    status_q[P_OVF_B]             = ovf_q[1];
    status_q[P_SAT_A]             = sat_q[0];
    status_q[P_SAT_B]             = sat_q[1];
    status_q[P_OVF_S]             = |ovf_q;
    status_q[P_SAT_S]             = |sat_q;
    status_q[P_LOOP]              = loop_q;
    status_q[P_DC]                = cond_q.dc;
    status_q[P_IPL_L +: IPL_W]    = ipl_q;
    status_q[P_RPT]               = rpt_q;
    status_q[P_N]                 = cond_q.n;
    status_q[P_OV]                = cond_q.ov;
    status_q[P_Z]                 = cond_q.z;
    status_q[P_C]                 = cond_q.c;
  end
endmodule

// File: rtl/dsp_status_reg_chk.sv
module dsp_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [15:0] sw_wr_data,
  input logic [15:0] status_q,
  input logic [1:0]  acc_wr,
  input logic [1:0]  acc_sat,
  input logic        irq_ipl_we,
  input logic        nest_dis,
  input logic        ipl_hi,
  input logic [3:0]  eff_prio,
  input logic        user_irq_off
);
  assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr[0] |=> $stable(status_q[15]));

  assert_sat_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[13] && !(sw_wr_en && (!sw_wr_data[13] || !sw_wr_data[10]))) |=> status_q[13]);

  assert_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[12] && !acc_sat[1]) |=> !status_q[12]);

  assert_sum_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !sw_wr_data[10] && acc_sat == 2'b00) |=> (status_q[13:12] == 2'b00));

  assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sat[0] |=> status_q[13]);

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[11] == (status_q[15] | status_q[14])) && (status_q[10] == (status_q[13] | status_q[12])));

  assert_ipl_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_dis && !irq_ipl_we) |=> $stable(status_q[7:5]));

  assert_eff_prio_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_prio == {ipl_hi, status_q[7:5]}) && (user_irq_off == ipl_hi));
endmodule

bind dsp_status_reg dsp_status_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_wr_en    (sw_wr_en),
  .sw_wr_data  (sw_wr_data),
  .status_q    (status_q),
  .acc_wr      (acc_wr),
  .acc_sat     (acc_sat),
  .irq_ipl_we  (irq_ipl_we),
  .nest_dis    (nest_dis),
  .ipl_hi      (ipl_hi),
  .eff_prio    (eff_prio),
  .user_irq_off(user_irq_off)
);

// File: tb/dsp_status_reg_test.sv
module dsp_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [15:0] sw_wr_data = '0;
  logic [15:0] status_q;
  logic [1:0]  acc_wr = '0, acc_ovf = '0, acc_sat = '0;
  logic        alu_we = 1'b0;
  logic [4:0]  alu_flags = '0;
  logic        loop_active = 1'b0, rpt_active = 1'b0;
  logic        irq_ipl_we = 1'b0;
  logic [2:0]  irq_ipl = '0;
  logic        nest_dis = 1'b0, ipl_hi = 1'b0;
  logic [3:0]  eff_prio;
  logic        user_irq_off;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Behavioural reference state
  bit m_oa, m_ob, m_sa, m_sb, m_da, m_ra;
  bit [4:0] m_cond;
  bit [2:0] m_ipl;

  always #10 clk = ~clk;

  dsp_status_reg uut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .status_q(status_q), .acc_wr(acc_wr), .acc_ovf(acc_ovf), .acc_sat(acc_sat),
    .alu_we(alu_we), .alu_flags(alu_flags), .loop_active(loop_active),
    .rpt_active(rpt_active), .irq_ipl_we(irq_ipl_we), .irq_ipl(irq_ipl),
    .nest_dis(nest_dis), .ipl_hi(ipl_hi), .eff_prio(eff_prio),
    .user_irq_off(user_irq_off)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oa = 0; m_ob = 0; m_sa = 0; m_sb = 0; m_da = 0; m_ra = 0;
      m_cond = 0; m_ipl = 0;
    end else begin
      if (acc_wr[0]) m_oa = acc_ovf[0];
      if (acc_wr[1]) m_ob = acc_ovf[1];
      if (acc_sat[0]) m_sa = 1;
      else if (sw_wr_en && (sw_wr_data[13] == 0 || sw_wr_data[10] == 0)) m_sa = 0;
      if (acc_sat[1]) m_sb = 1;
      else if (sw_wr_en && (sw_wr_data[12] == 0 || sw_wr_data[10] == 0)) m_sb = 0;
      m_da = loop_active;
      m_ra = rpt_active;
      if (alu_we) m_cond = alu_flags;
      else if (sw_wr_en) m_cond = {sw_wr_data[8], sw_wr_data[3:0]};
      if (irq_ipl_we) m_ipl = irq_ipl;
      else if (sw_wr_en && !nest_dis) m_ipl = sw_wr_data[7:5];
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R3 overflow bits", {14'd0, status_q[15], status_q[14]}, {14'd0, m_oa, m_ob});
    chk("R4 sticky bits", {14'd0, status_q[13], status_q[12]}, {14'd0, m_sa, m_sb});
    chk("R8 summary bits", {14'd0, status_q[11], status_q[10]},
        {14'd0, m_oa | m_ob, m_sa | m_sb});
    chk("R9 loop/repeat", {14'd0, status_q[9], status_q[4]}, {14'd0, m_da, m_ra});
    chk("R10 condition flags", {11'd0, status_q[8], status_q[3:0]}, {11'd0, m_cond});
    chk("R11 priority field", {13'd0, status_q[7:5]}, {13'd0, m_ipl});
    chk("R12 effective priority", {11'd0, user_irq_off, eff_prio},
        {11'd0, ipl_hi, ipl_hi, m_ipl});
    chk("R2 full word", status_q,
        {m_oa, m_ob, m_sa, m_sb, m_oa | m_ob, m_sa | m_sb, m_da, m_cond[4],
         m_ipl, m_ra, m_cond[3:0]});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic idle();
    sw_wr_en = 0; acc_wr = 0; acc_sat = 0; alu_we = 0; irq_ipl_we = 0;
  endtask

  initial begin
    #1;
    repeat (2) @(negedge clk);
    chk("R1 reset word", status_q, 16'h0000);
    chk("R1 reset priority", {12'd0, eff_prio}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: saturate both accumulators, then hold with no clear
    acc_sat = 2'b11; step(); idle();
    chk("R4 saturated", status_q & 16'h3400, 16'h3400);
    sw_wr_data = 16'hFFFF; sw_wr_en = 1; step(); idle();
    chk("R5 ones leave sticky bits set", status_q & 16'h3400, 16'h3400);

    // R6: summary clear fans out
    sw_wr_data = 16'hFBFF; sw_wr_en = 1; step(); idle();
    chk("R6 summary clear", status_q & 16'h3400, 16'h0000);

    // R5: ones cannot set the sticky bits
    sw_wr_data = 16'hFFFF; sw_wr_en = 1; step(); idle();
    chk("R5 cannot set", status_q & 16'hFC10, 16'h0000);

    // R7: event and clear together
    acc_sat = 2'b01; sw_wr_data = 16'h0000; sw_wr_en = 1; step(); idle();
    chk("R7 event wins", status_q & 16'h3400, 16'h2400);

    // R5: individual clear of A only leaves B
    acc_sat = 2'b10; step(); idle();
    sw_wr_data = 16'hDFFF; sw_wr_en = 1; step(); idle();
    chk("R5 clear A only", status_q & 16'h3400, 16'h1400);

    // R3: overflow update and hold
    acc_wr = 2'b01; acc_ovf = 2'b01; step(); idle();
    chk("R3 overflow A", status_q & 16'hC800, 16'h8800);
    acc_ovf = 2'b00; step();
    chk("R3 overflow hold", status_q & 16'hC800, 16'h8800);

    // R10: ALU wins over software
    alu_we = 1; alu_flags = 5'b10101; sw_wr_en = 1; sw_wr_data = 16'h0000; step(); idle();
    chk("R10 alu wins", status_q & 16'h010F, 16'h0105);

    // R11: lock and controller priority
    nest_dis = 1; sw_wr_en = 1; sw_wr_data = 16'h00E0; step(); idle();
    chk("R11 locked", status_q & 16'h00E0, 16'h0000);
    irq_ipl_we = 1; irq_ipl = 3'd5; sw_wr_en = 1; sw_wr_data = 16'h0020; nest_dis = 0;
    step(); idle();
    chk("R11 controller wins", status_q & 16'h00E0, 16'h00A0);

    // R12: fourth priority bit
    ipl_hi = 1; #1;
    chk("R12 high bit", {11'd0, user_irq_off, eff_prio}, 16'h001D);

    // R9: loop/repeat follow one clock later
    loop_active = 1; rpt_active = 1; step();
    chk("R9 follow", status_q & 16'h0210, 16'h0210);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      sw_wr_en    = ($urandom_range(0, 3) == 0);
      sw_wr_data  = 16'($urandom);
      acc_wr      = 2'($urandom);
      acc_ovf     = 2'($urandom);
      acc_sat     = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      alu_we      = ($urandom_range(0, 2) == 0);
      alu_flags   = 5'($urandom);
      loop_active = 1'($urandom);
      rpt_active  = 1'($urandom);
      irq_ipl_we  = ($urandom_range(0, 7) == 0);
      irq_ipl     = 3'($urandom);
      nest_dis    = 1'($urandom);
      ipl_hi      = 1'($urandom);
      step();
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 20000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule